// File: doc/BRIEF.md
# Upset-Masking Redundant Register with Agreement Hold

This block stores a word of data in a form that tolerates a single transient upset per bit. Each bit is captured twice, into two independent copy registers, on the same clock edge. A third storage stage per bit watches the two copies. When they agree, it takes their common value. When they disagree, it keeps the value it already had. A flip in one copy therefore never reaches the output. The output simply stays where it was for that cycle.

The agreement stage is the synchronous equivalent of an agreement-or-hold gate (Muller C-element), modelled here as a clocked register. It sits after the copies, so data reaches the output two clock edges after it is presented. A per-bit disagreement flag exposes which bits currently have split copies. Two per-copy flip inputs let a bench or fault campaign corrupt one copy's captured value for a single cycle. In normal use these inputs are tied low. The word width is a parameter, and every bit has its own copies, flag and hold stage.

Top module: `agree_hold_reg`

## Requirements
- R1: While `rst` is high at a rising edge, both copies and the output stage clear to 0, even if flip inputs are active; after that edge `dout` and `split` read all zeros.
- R2: With both flip inputs at 0, both copies capture `din` at every rising edge, and `dout` equals the `din` presented two rising edges earlier.
- R3: At a rising edge, every bit whose two copies agree loads that common value into `dout`.
- R4: At a rising edge, every bit whose two copies disagree keeps its previous `dout` value.
- R5: `split[i]` is 1 exactly while the two copies of bit i hold different values; it is never set while both copies were loaded with equal flip masks.
- R6: A 1 on `inj_a[i]` (or `inj_b[i]`) at a rising edge stores the inverse of `din[i]` in that copy for that edge only; the next clean edge restores agreement.
- R7: Bits are independent: a split in one bit does not alter the capture, flag or output of any other bit.
- R8: The same flip applied to both copies of a bit is not corrected: the copies agree on the inverted value, `split` stays 0, and `dout` takes the inverted value one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH | Data to be stored |
| inj_a | input | WIDTH | Per-bit flip mask for copy A, tie to 0 in use |
| inj_b | input | WIDTH | Per-bit flip mask for copy B, tie to 0 in use |
| dout | output | WIDTH | Agreement-hold output |
| split | output | WIDTH | Per-bit flag: the two copies currently differ |

## Verification
A corrupted copy shows on `split` right after the edge that loaded it. It shows on `dout` one edge later. If the hold were wrong, the output would take the corrupted value. If the capture were wrong, the output would fail to follow clean data within two edges. The bench sweeps all data values of the default word against clean, single-copy, disjoint two-copy and coincident flip masks. It compares `dout` and `split` after every edge, so any such error is caught on the first cycle in which it is visible at the ports.

// File: rtl/agree_hold_pkg.sv
package agree_hold_pkg;

  // Next value of one agreement-hold stage: take the copies when they
  // match, otherwise keep the present output.
  function automatic logic ah_next(input logic cur, input logic ca, input logic cb);
    logic agree;
    agree = ~(ca ^ cb);
    return agree ? ca : cur;
  endfunction

  // Value one copy captures, given the data and its flip mask bit.
  function automatic logic ah_capture(input logic d, input logic flip);
    return d ^ flip;
  endfunction

endpackage

// File: rtl/ah_copy_bank.sv
module ah_copy_bank
  import agree_hold_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] flip,
  output logic [WIDTH-1:0] cpy
);

  logic [WIDTH-1:0] cap_next;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cap
    assign cap_next[i] = ah_capture(din[i], flip[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) cpy <= '0;
    else     cpy <= cap_next;
  end

endmodule

// File: rtl/ah_hold_bit.sv
module ah_hold_bit
  import agree_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ca,
  input  logic cb,
  output logic q
);

  logic q_next;

  assign q_next = ah_next(q, ca, cb);

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_next;
  end

  // R1: reset clears the hold stage
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (q == 1'b0));

  // R3: agreeing copies are loaded
  a_r3_follow_agree: assert property (@(posedge clk) disable iff (rst)
    (ca == cb) |=> (q == $past(ca)));

  // R4: split copies leave the output untouched
  a_r4_hold_on_split: assert property (@(posedge clk) disable iff (rst)
    (ca != cb) |=> $stable(q));

endmodule

// File: rtl/agree_hold_reg.sv
module agree_hold_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] inj_a,
  input  logic [WIDTH-1:0] inj_b,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] split
);

  logic [WIDTH-1:0] copy_a;
  logic [WIDTH-1:0] copy_b;

  ah_copy_bank #(.WIDTH(WIDTH)) u_copy_a (
    .clk(clk), .rst(rst), .din(din), .flip(inj_a), .cpy(copy_a)
  );

  ah_copy_bank #(.WIDTH(WIDTH)) u_copy_b (
    .clk(clk), .rst(rst), .din(din), .flip(inj_b), .cpy(copy_b)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    ah_hold_bit u_hold (
      .clk(clk), .rst(rst), .ca(copy_a[i]), .cb(copy_b[i]), .q(dout[i])
    );
  end

  assign split = copy_a ^ copy_b;

  // R5: equal flip masks never leave a split behind
  a_r5_equal_flips_no_split: assert property (@(posedge clk) disable iff (rst)
    (inj_a == inj_b) |=> (split == '0));

  // R1: reset leaves no split
  a_r1_reset_no_split: assert property (@(posedge clk) rst |=> (split == '0));

  // R2: two clean, equal captures in a row put that data on the output
  a_r2_clean_latency: assert property (@(posedge clk) disable iff (rst)
    (inj_a == '0 && inj_b == '0 && $past(inj_a) == '0 && $past(inj_b) == '0
     && !$past(rst) && din == $past(din)) |=> (dout == $past(din)));

endmodule

// File: tb/sim_agree_hold_reg.sv
module sim_agree_hold_reg;

  localparam int  W          = 8;
  localparam time CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] inj_a = '0;
  logic [W-1:0] inj_b = '0;
  logic [W-1:0] dout;
  logic [W-1:0] split;

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0] m_a = '0;
  logic [W-1:0] m_b = '0;
  logic [W-1:0] m_q = '0;

  agree_hold_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .din(din), .inj_a(inj_a), .inj_b(inj_b),
    .dout(dout), .split(split)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock with given stimulus; model from the requirements, then compare.
  task automatic step(input logic r, input logic [W-1:0] d,
                      input logic [W-1:0] fa, input logic [W-1:0] fb,
                      input string req_q, input string req_s);
    logic [W-1:0] diff;
    @(negedge clk);
    rst = r; din = d; inj_a = fa; inj_b = fb;
    @(posedge clk);
    #1;
    if (r) begin
      m_a = '0; m_b = '0; m_q = '0;
    end else begin
      diff = m_a ^ m_b;
      m_q  = (m_q & diff) | (m_a & ~diff);
      m_a  = d ^ fa;
      m_b  = d ^ fb;
    end
    chk(req_q, dout, m_q);
    chk(req_s, split, m_a ^ m_b);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset with flips active
    for (int k = 0; k < 3; k++) step(1'b1, 8'hA5, 8'hFF, 8'h0F, "R1 dout", "R1 split");

    // R2: clean sweep of every data value
    for (int v = 0; v < 256; v++) step(1'b0, v[W-1:0], '0, '0, "R2 dout", "R2 split");
    step(1'b0, 8'h3C, '0, '0, "R2 dout", "R2 split");
    step(1'b0, 8'h3C, '0, '0, "R2 dout", "R2 split");
    chk("R2 settled", dout, 8'h3C);

    // R4 / R6: single-copy flips, alternating copy, each followed by a clean edge
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] m;
      m = W'(1) << (v % W);
      if (v[3]) step(1'b0, v[W-1:0], m, '0, "R4 dout", "R6 split");
      else      step(1'b0, v[W-1:0], '0, m, "R4 dout", "R6 split");
      step(1'b0, v[W-1:0], '0, '0, "R3 dout", "R6 split");
    end

    // R7: disjoint multi-bit masks on both copies over changing data
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] ma;
      ma = W'(v * 37);
      step(1'b0, ~v[W-1:0], ma & 8'h55, ma & 8'hAA, "R7 dout", "R7 split");
    end
    step(1'b0, 8'h81, '0, '0, "R3 dout", "R5 split");
    step(1'b0, 8'h81, '0, '0, "R3 dout", "R5 split");

    // R8: coincident flips are not corrected
    step(1'b0, 8'h81, 8'h18, 8'h18, "R8 dout", "R8 split");
    chk("R8 split zero", split, '0);
    step(1'b0, 8'h81, '0, '0, "R8 dout", "R8 split");
    chk("R8 corrupted value", dout, 8'h99);
    step(1'b0, 8'h81, '0, '0, "R3 dout", "R5 split");
    chk("R3 recovered", dout, 8'h81);

    // R5: a held split clears on the next clean edge; R4 hold across data change
    step(1'b0, 8'hF0, 8'h01, '0, "R4 dout", "R5 split");
    chk("R5 flag bit0", split, 8'h01);
    step(1'b0, 8'h0F, '0, '0, "R4 dout", "R5 split");
    chk("R4 bit0 held", dout[0], m_q[0]);

    // R1: reset mid-run
    step(1'b1, 8'hFF, 8'h3C, 8'hC3, "R1 dout", "R1 split");
    chk("R1 mid-run dout", dout, '0);
    step(1'b0, 8'h00, '0, '0, "R1 dout", "R1 split");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule